// File: doc/BRIEF.md
# Weighted Score Output Port Selector

This block picks one output port for a header flit in a 2D mesh router. The adaptive routing function offers a set of candidate ports among north, east, south and west. The block drops any candidate that another header flit has already reserved. It then scores each remaining port from three metrics and reports the index of the best port. The metrics are a precomputed link selection probability, the free slot count of the downstream input buffer, and the router's instantaneous power increase.

The free slot count is scaled against a maximum buffer size, and the power increase against a maximum power value. Each result is an 8-bit unsigned fraction that saturates at 255. The probability arrives already as an 8-bit fraction. Three 8-bit weights set how much each metric counts. They reset to 77, 102 and 77 (about 0.3, 0.4 and 0.3 of 256), and software can rewrite them through a small write port. The power term is inverted, so a port whose use would raise power a lot loses score.

Requests enter through a valid/ready handshake and results leave through another. The input is accepted when `in_valid` and `in_ready` are both high. A result stays on the output until the consumer takes it by asserting `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. So a stalled consumer stalls the requester, and nothing is dropped.

Top module: `port_score_sel`

## Requirements
- R1: After reset, `out_valid`, `res_hit` and `res_port` are 0 and `in_ready` is 1. The weights read 77 (probability), 102 (buffer) and 77 (power).
- R2: Port index i (0 north, 1 east, 2 south, 3 west) is eligible only when bit i of `cand` is 1 and bit i of `resv` is 0. `res_hit` is 1 exactly when at least one port is eligible, and the reported port is always an eligible one.
- R3: The score of port i is Wp·P + Wb·B + Ww·(255 − D). P, B and D are the 8-bit probability, normalized buffer and normalized power fractions of that port, and all products are kept at full width.
- R4: B = floor(free·256 / MAX_BUF) and D = floor(delta·256 / MAX_PWR), each clamped to 255. The defaults are MAX_BUF = 16 and MAX_PWR = 200.
- R5: Among the eligible ports, the one with the highest score is reported.
- R6: When eligible ports tie on the highest score, the lowest index wins, giving the order north, east, south, west.
- R7: When no port is eligible, `res_hit` is 0 and `res_port` is 0.
- R8: A result appears on the output in the clock cycle after the request is accepted (`in_valid && in_ready` at a rising edge). `out_valid` falls after a handshake on the output when no new request is accepted in the same cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, the result holds stable and `in_ready` is 0. Once `out_ready` rises, a waiting request is accepted in that same cycle.
- R10: A weight write (`wgt_we` = 1) with `wgt_sel` 0, 1 or 2 loads `wgt_data` into the probability, buffer or power weight. It affects requests accepted in later cycles. A write with `wgt_sel` = 3 changes no weight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wgt_we | input | 1 | Weight write strobe |
| wgt_sel | input | 2 | Weight select: 0 probability, 1 buffer, 2 power, 3 none |
| wgt_data | input | 8 | Weight value to write |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| cand | input | 4 | Candidate port mask, bit 0 north, 1 east, 2 south, 3 west |
| resv | input | 4 | Port already reserved mask, same bit order |
| prob | input | 32 | Four 8-bit link probabilities, port i in bits 8i+7:8i |
| free_cnt | input | 20 | Four 5-bit downstream free slot counts, port i in bits 5i+4:5i |
| pwr_delta | input | 32 | Four 8-bit power increases, port i in bits 8i+7:8i |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | An eligible port was found |
| res_port | output | 2 | Winning port index, 0 when none |

## Verification
Every result is due exactly one cycle after its request is accepted. The bench therefore drives a request at a falling edge, lets one rising edge capture it, and checks the output at the next falling edge. The output drains one cycle after the handshake with `out_ready` high. The stall sequence checks the held result and a low `in_ready` at each falling edge while `out_ready` is low. It then checks that the waiting request appears one cycle after `out_ready` rises. After a weight write, the bench starts its next request no earlier than the following falling edge, so the new weight is already in effect.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int NPORT  = 4;
  localparam int PORT_W = 2;
  localparam int FRAC_W = 8;
  localparam int SCORE_W = 2 * FRAC_W + 2;

  typedef enum logic [PORT_W-1:0] {
    DIR_NORTH = 2'd0,
    DIR_EAST  = 2'd1,
    DIR_SOUTH = 2'd2,
    DIR_WEST  = 2'd3
  } dir_e;

  typedef enum logic [1:0] {
    WSEL_PROB = 2'd0,
    WSEL_BUF  = 2'd1,
    WSEL_PWR  = 2'd2,
    WSEL_NONE = 2'd3
  } wsel_e;

  typedef struct packed {
    logic [FRAC_W-1:0] prob;
    logic [FRAC_W-1:0] buf_w;
    logic [FRAC_W-1:0] pwr;
  } weights_t;
endpackage

// File: rtl/spw_norm.sv
module spw_norm #(
  parameter int IN_W    = 5,
  parameter int MAX_VAL = 16,
  parameter int FRAC_W  = 8
) (
  input  logic [IN_W-1:0]   raw,
  output logic [FRAC_W-1:0] frac
);
  localparam int SW = IN_W + FRAC_W;
  localparam logic [SW-1:0] DIVISOR = SW'(MAX_VAL);

  logic [SW-1:0] scaled;
  logic          over;

  always_comb begin
    scaled = {raw, {FRAC_W{1'b0}}} / DIVISOR;
    over   = |scaled[SW-1:FRAC_W];
    frac   = over ? {FRAC_W{1'b1}} : scaled[FRAC_W-1:0];
  end
endmodule

// File: rtl/spw_score.sv
module spw_score #(
  parameter int FRAC_W  = 8,
  parameter int SCORE_W = 18
) (
  input  logic [FRAC_W-1:0]  prob,
  input  logic [FRAC_W-1:0]  nbuf,
  input  logic [FRAC_W-1:0]  npwr,
  input  logic [FRAC_W-1:0]  w_prob,
  input  logic [FRAC_W-1:0]  w_buf,
  input  logic [FRAC_W-1:0]  w_pwr,
  output logic [SCORE_W-1:0] score
);
  localparam int PW = 2 * FRAC_W;

  logic [PW-1:0]     term_p;
  logic [PW-1:0]     term_b;
  logic [PW-1:0]     term_w;
  logic [FRAC_W-1:0] pwr_head;

  always_comb begin
    pwr_head = ~npwr;
    term_p   = PW'(w_prob) * PW'(prob);
    term_b   = PW'(w_buf)  * PW'(nbuf);
    term_w   = PW'(w_pwr)  * PW'(pwr_head);
    score    = SCORE_W'(term_p) + SCORE_W'(term_b) + SCORE_W'(term_w);
  end
endmodule

// File: rtl/spw_pick.sv
module spw_pick #(
  parameter int NPORT   = 4,
  parameter int PORT_W  = 2,
  parameter int SCORE_W = 18
) (
  input  logic [NPORT-1:0]         elig,
  input  logic [NPORT*SCORE_W-1:0] scores,
  output logic                     hit,
  output logic [PORT_W-1:0]        idx
);
  logic [SCORE_W-1:0] best;
  logic [SCORE_W-1:0] cur;

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    cur  = '0;
    for (int i = 0; i < NPORT; i++) begin
      cur = scores[i*SCORE_W +: SCORE_W];
      if (elig[i] && (!hit || cur > best)) begin
        hit  = 1'b1;
        best = cur;
        idx  = PORT_W'(i);
      end
    end
  end
endmodule

// File: rtl/spw_wregs.sv
module spw_wregs #(
  parameter int FRAC_W    = 8,
  parameter int W_PROB_RST = 77,
  parameter int W_BUF_RST  = 102,
  parameter int W_PWR_RST  = 77
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [FRAC_W-1:0] data,
  output spw_pkg::weights_t wts
);
  import spw_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wts.prob  <= FRAC_W'(W_PROB_RST);
      wts.buf_w <= FRAC_W'(W_BUF_RST);
      wts.pwr   <= FRAC_W'(W_PWR_RST);
    end else if (we) begin
      case (wsel_e'(sel))
        WSEL_PROB: wts.prob  <= data;
        WSEL_BUF:  wts.buf_w <= data;
        WSEL_PWR:  wts.pwr   <= data;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/port_score_sel.sv
module port_score_sel #(
  parameter int BUF_W      = 5,
  parameter int MAX_BUF    = 16,
  parameter int PWR_W      = 8,
  parameter int MAX_PWR    = 200,
  parameter int W_PROB_RST = 77,
  parameter int W_BUF_RST  = 102,
  parameter int W_PWR_RST  = 77
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wgt_we,
  input  logic [1:0]                        wgt_sel,
  input  logic [spw_pkg::FRAC_W-1:0]        wgt_data,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [spw_pkg::NPORT-1:0]         cand,
  input  logic [spw_pkg::NPORT-1:0]         resv,
  input  logic [spw_pkg::NPORT*spw_pkg::FRAC_W-1:0] prob,
  input  logic [spw_pkg::NPORT*BUF_W-1:0]   free_cnt,
  input  logic [spw_pkg::NPORT*PWR_W-1:0]   pwr_delta,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic                              res_hit,
  output logic [spw_pkg::PORT_W-1:0]        res_port
);
  import spw_pkg::*;

  weights_t                 wts;
  logic [NPORT-1:0]         elig;
  logic [NPORT*SCORE_W-1:0] scores;
  logic                     pick_hit;
  logic [PORT_W-1:0]        pick_idx;
  logic                     accept;

  spw_wregs #(
    .FRAC_W(FRAC_W), .W_PROB_RST(W_PROB_RST),
    .W_BUF_RST(W_BUF_RST), .W_PWR_RST(W_PWR_RST)
  ) u_wregs (
    .clk(clk), .rst_n(rst_n), .we(wgt_we), .sel(wgt_sel),
    .data(wgt_data), .wts(wts)
  );

  assign elig = cand & ~resv;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic [FRAC_W-1:0] nbuf;
    logic [FRAC_W-1:0] npwr;

    spw_norm #(.IN_W(BUF_W), .MAX_VAL(MAX_BUF), .FRAC_W(FRAC_W)) u_nbuf (
      .raw(free_cnt[g*BUF_W +: BUF_W]), .frac(nbuf)
    );
    spw_norm #(.IN_W(PWR_W), .MAX_VAL(MAX_PWR), .FRAC_W(FRAC_W)) u_npwr (
      .raw(pwr_delta[g*PWR_W +: PWR_W]), .frac(npwr)
    );
    spw_score #(.FRAC_W(FRAC_W), .SCORE_W(SCORE_W)) u_score (
      .prob(prob[g*FRAC_W +: FRAC_W]), .nbuf(nbuf), .npwr(npwr),
      .w_prob(wts.prob), .w_buf(wts.buf_w), .w_pwr(wts.pwr),
      .score(scores[g*SCORE_W +: SCORE_W])
    );
  end

  spw_pick #(.NPORT(NPORT), .PORT_W(PORT_W), .SCORE_W(SCORE_W)) u_pick (
    .elig(elig), .scores(scores), .hit(pick_hit), .idx(pick_idx)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_port  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res_hit   <= pick_hit;
      res_port  <= pick_hit ? pick_idx : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spw_check.sv
module spw_check #(
  parameter int NPORT  = 4,
  parameter int PORT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [NPORT-1:0]  cand,
  input logic [NPORT-1:0]  resv,
  input logic              out_valid,
  input logic              out_ready,
  input logic              res_hit,
  input logic [PORT_W-1:0] res_port
);
  logic [NPORT-1:0] elig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) elig_q <= '0;
    else if (in_valid && in_ready) elig_q <= cand & ~resv;
  end

  a_r8_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_hit) && $stable(res_port)));

  a_r7_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !res_hit) |-> (res_port == '0));

  a_r2_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_hit) |-> elig_q[res_port]);

  a_r2_hit_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_hit == (elig_q != '0)));
endmodule

bind port_score_sel spw_check #(.NPORT(spw_pkg::NPORT), .PORT_W(spw_pkg::PORT_W)) u_spw_check (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cand(cand), .resv(resv), .out_valid(out_valid), .out_ready(out_ready),
  .res_hit(res_hit), .res_port(res_port)
);

// File: tb/tb_port_score_sel.sv
module tb_port_score_sel;
  localparam int CLK_P   = 10;
  localparam int BUF_W   = 5;
  localparam int MAX_BUF = 16;
  localparam int PWR_W   = 8;
  localparam int MAX_PWR = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wgt_we = 1'b0;
  logic [1:0]  wgt_sel = 2'd0;
  logic [7:0]  wgt_data = 8'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  cand = 4'd0;
  logic [3:0]  resv = 4'd0;
  logic [31:0] prob = 32'd0;
  logic [19:0] free_cnt = 20'd0;
  logic [31:0] pwr_delta = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        res_hit;
  logic [1:0]  res_port;

  int checks = 0;
  int failures = 0;
  int wp = 77, wb = 102, ww = 77;

  port_score_sel dut (
    .clk(clk), .rst_n(rst_n), .wgt_we(wgt_we), .wgt_sel(wgt_sel),
    .wgt_data(wgt_data), .in_valid(in_valid), .in_ready(in_ready),
    .cand(cand), .resv(resv), .prob(prob), .free_cnt(free_cnt),
    .pwr_delta(pwr_delta), .out_valid(out_valid), .out_ready(out_ready),
    .res_hit(res_hit), .res_port(res_port)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 normalization
  function automatic int norm_buf(int c);
    int v = (c * 256) / MAX_BUF;
    return (v > 255) ? 255 : v;
  endfunction
  function automatic int norm_pwr(int d);
    int v = (d * 256) / MAX_PWR;
    return (v > 255) ? 255 : v;
  endfunction

  // R3 score
  function automatic int score_of(int i);
    int p = int'(prob[i*8 +: 8]);
    int b = norm_buf(int'(free_cnt[i*BUF_W +: BUF_W]));
    int d = norm_pwr(int'(pwr_delta[i*PWR_W +: PWR_W]));
    return wp * p + wb * b + ww * (255 - d);
  endfunction

  // R2, R5, R6, R7 selection; returns -1 when no port is eligible
  function automatic int exp_port();
    int best = -1;
    int bs = 0;
    for (int i = 0; i < 4; i++) begin
      if (cand[i] && !resv[i]) begin
        if (best < 0 || score_of(i) > bs) begin
          best = i;
          bs = score_of(i);
        end
      end
    end
    return best;
  endfunction

  task automatic wr_weight(int sel, int val);
    wgt_we = 1'b1; wgt_sel = 2'(sel); wgt_data = 8'(val);
    @(negedge clk);
    wgt_we = 1'b0;
    if (sel == 0) wp = val;
    else if (sel == 1) wb = val;
    else if (sel == 2) ww = val;
  endtask

  // drive at a falling edge, captured at the next rising edge, checked one falling edge later
  task automatic do_req(string req);
    int e = exp_port();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, int'(out_valid), 1);
    chk({req, " res_hit"}, int'(res_hit), (e >= 0) ? 1 : 0);
    chk({req, " res_port"}, int'(res_port), (e >= 0) ? e : 0);
  endtask

  task automatic set_port(int i, int p, int f, int d);
    prob[i*8 +: 8] = 8'(p);
    free_cnt[i*BUF_W +: BUF_W] = BUF_W'(f);
    pwr_delta[i*PWR_W +: PWR_W] = PWR_W'(d);
  endtask

  task automatic rand_inputs();
    cand = 4'($urandom);
    resv = 4'($urandom) & 4'($urandom);
    for (int i = 0; i < 4; i++) begin
      set_port(i, $urandom % 256, $urandom % 32, $urandom % 256);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 res_hit", int'(res_hit), 0);
    chk("R1 res_port", int'(res_port), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    // R1 default weights seen through the selection: probability vs buffer trade-off
    cand = 4'b0011; resv = 4'b0000;
    set_port(0, 255, 0, 0); set_port(1, 0, 16, 0);
    set_port(2, 0, 0, 0);   set_port(3, 0, 0, 0);
    do_req("R1 default weights");

    // R7 no eligible port: all candidates reserved
    cand = 4'b1011; resv = 4'b1111;
    do_req("R7 all reserved");
    cand = 4'b0000; resv = 4'b0000;
    do_req("R7 empty candidates");

    // R2 reserved best port is skipped
    cand = 4'b1111; resv = 4'b0001;
    set_port(0, 255, 31, 0); set_port(1, 10, 2, 100);
    set_port(2, 50, 5, 50);  set_port(3, 20, 1, 150);
    do_req("R2 reserved skip");

    // R6 ties resolved north, east, south, west
    for (int i = 0; i < 4; i++) set_port(i, 100, 8, 100);
    cand = 4'b1111; resv = 4'b0000;
    do_req("R6 tie all");
    cand = 4'b1110;
    do_req("R6 tie from east");
    cand = 4'b1100;
    do_req("R6 tie south west");

    // R4 clamp: buffers at and beyond MAX_BUF, power at and beyond MAX_PWR
    cand = 4'b1111; resv = 4'b0000;
    set_port(0, 0, 16, 199); set_port(1, 0, 31, 199);
    set_port(2, 0, 15, 200); set_port(3, 0, 15, 255);
    do_req("R4 clamp tie");
    set_port(0, 0, 3, 255); set_port(1, 0, 3, 200);
    set_port(2, 0, 3, 201); set_port(3, 0, 3, 199);
    do_req("R4 power clamp");

    // R10 weight writes, including an ignored select
    wr_weight(0, 255); wr_weight(1, 0); wr_weight(2, 0);
    cand = 4'b1111;
    set_port(0, 10, 31, 0); set_port(1, 200, 0, 255);
    set_port(2, 100, 20, 0); set_port(3, 199, 31, 0);
    do_req("R10 probability only");
    wr_weight(3, 0);
    do_req("R10 select 3 ignored");
    wr_weight(1, 255);
    do_req("R10 buffer weight");
    wr_weight(0, 77); wr_weight(1, 102); wr_weight(2, 77);

    // R9 back-pressure
    out_ready = 1'b0;
    cand = 4'b0001; resv = 4'b0000;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R8 stalled result valid", int'(out_valid), 1);
    chk("R9 first port", int'(res_port), 0);
    chk("R9 in_ready low", int'(in_ready), 0);
    cand = 4'b1000;
    @(negedge clk);
    chk("R9 held valid", int'(out_valid), 1);
    chk("R9 held port", int'(res_port), 0);
    chk("R9 held in_ready", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 waiting request taken", int'(res_port), 3);
    chk("R9 waiting request valid", int'(out_valid), 1);
    @(negedge clk);
    chk("R8 drain", int'(out_valid), 0);

    // R3 R5 random traffic with occasional weight changes
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 49) wr_weight($urandom % 3, $urandom % 256);
      rand_inputs();
      do_req("R3 R5 random");
      if (n % 7 == 0) begin
        @(negedge clk);
        chk("R8 idle drain", int'(out_valid), 0);
      end
    end

    finish_run();
  end
endmodule